// File: doc/BRIEF.md
# Battery Cell Protection Controller

This block is the digital supervisor of a single rechargeable lithium cell. Analog comparators outside the block report, already synchronized to the clock, whether the cell is over the overvoltage level, below the charge-enable level, below the undervoltage level or below the short-circuit depletion level. They also report whether the drop across the pass FETs is above the overcurrent level, whether the pack terminal has recovered, whether a charger is present and whether the die is too hot. A power-switch input tells when the switch pin is pulled low. From these inputs the block drives the charge-FET enable, the discharge-FET enable, a test-current enable and a recovery-charge enable, and it tracks an active mode and a sleep mode.

Each fault has its own qualification delay, counted in ticks of a timebase strobe, and its own rule for recovery. Faults leave sticky flags that only the host clears. The host reaches the flags and the two FET permission bits through a small register port with two addresses. Writes take effect at the clock edge. Reads are combinational.

Top module: `cell_guard`

## Requirements
- R1: After reset the block is active and address 0 reads 0x3F, address 1 reads 0x02. Address 0 holds CE at bit 0, DE at bit 1, the charge output at bit 2 and the discharge output at bit 3 (both read-only), DOC at bit 4, UV at bit 5, OV at bit 6 and 0 at bit 7. Address 1 holds OT at bit 0, PSF at bit 1 and 0 above.
- R2: An overvoltage held for OV_DLY ticks, with the tick high on every cycle, sets OV and turns off the charge output one clock later. The discharge output stays on.
- R3: Once an overvoltage has tripped, the charge output comes back on at the next clock edge after the cell falls below the charge-enable level or the FET drop exceeds the overcurrent level, unless another fault blocks it.
- R4: A delay count starts again from zero when its condition drops out before the count expires.
- R5: An overcurrent held for OC_DLY ticks, or a depletion held for SC_DLY ticks, sets DOC and turns off both outputs. It also raises the test-current enable, and the recovery-charge enable for a depletion trip only. All of these hold until the pack-recovered input is seen.
- R6: An undervoltage held for UV_DLY ticks sets UV, turns off both outputs and enters sleep.
- R7: In sleep both outputs are off and no fault is qualified. The block wakes when the switch pin is low, or when a charger is present and the cell is above the undervoltage level. A cell below the depletion level refuses the wake. The switch pin being low in active mode leaves both outputs on.
- R8: On waking, CE and DE are set to 1, and an overvoltage already present trips at once, with no delay.
- R9: Overtemperature turns off both outputs in the same cycle, with no clock edge. The outputs stay off until the input has cleared and the host writes OT to 0. A host write of OT=1 also turns both outputs off.
- R10: With CE=0 the charge output is off, and with DE=0 the discharge output is off. Writing 1 gives the permission back.
- R11: OV, UV and DOC stay set until the host writes 0. If a hardware set and a host write fall in the same cycle, the hardware set wins.
- R12: PSF is cleared when the switch pin is seen low. Hardware never sets it again. A host write of 1 restores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase strobe for the delay counters |
| cmp_ov | input | 1 | Cell above overvoltage level |
| cmp_below_ce | input | 1 | Cell below charge-enable level |
| cmp_uv | input | 1 | Cell below undervoltage level |
| cmp_sc | input | 1 | Cell below short-circuit depletion level |
| cmp_oc | input | 1 | FET drop above overcurrent level |
| pack_ok | input | 1 | Pack terminal recovered |
| charger_on | input | 1 | Charger present |
| hot | input | 1 | Overtemperature |
| sw_low | input | 1 | Power-switch pin pulled low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address (0 protection, 1 feature) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| chg_en | output | 1 | Charge-FET enable |
| dsg_en | output | 1 | Discharge-FET enable |
| test_en | output | 1 | Test-current enable |
| rechg_en | output | 1 | Recovery-charge enable |
| active | output | 1 | High in active mode, low in sleep |

## Verification
The bench builds the block with OV_DLY=3, UV_DLY=4, OC_DLY=2 and SC_DLY=1, and it holds the tick high. With these values each fault trips within a few cycles. That lets the bench sample the last cycle before each trip and the first cycle after it, and interrupt the overvoltage count one cycle short to show that it starts again. The short delays also keep the sleep-and-wake paths short, including a wake refused during depletion and a wake with an overvoltage already present.

// File: rtl/cell_guard_pkg.sv
// Shared constants for the cell protection controller: register addresses,
// bit positions inside the two host registers, and qualifier indices.
package cell_guard_pkg;
    localparam int DATA_W = 8;

    localparam logic ADDR_PROT = 1'b0;
    localparam logic ADDR_FEAT = 1'b1;

    // protection register bit positions
    localparam int B_CE  = 0;
    localparam int B_DE  = 1;
    localparam int B_CHG = 2;
    localparam int B_DSG = 3;
    localparam int B_DOC = 4;
    localparam int B_UV  = 5;
    localparam int B_OV  = 6;

    // feature register bit positions
    localparam int B_OT  = 0;
    localparam int B_PSF = 1;

    // qualifier indices
    localparam int NQ    = 4;
    localparam int QI_OV = 0;
    localparam int QI_UV = 1;
    localparam int QI_OC = 2;
    localparam int QI_SC = 3;
endpackage

// File: rtl/qual_timer.sv
// Fault qualification timer. It counts tick strobes while cond and en are
// both high and reports qual once DLY ticks have been seen. The count
// returns to zero as soon as cond or en drops. DLY=0 qualifies at once.
// Assumes cond is already synchronized to clk.
module qual_timer #(
    parameter int unsigned DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic cond,
    output logic qual
);
    localparam int W = (DLY < 1) ? 1 : $clog2(DLY + 1);
    localparam logic [W-1:0] LIM = W'(DLY);

    logic [W-1:0] cnt;

    // count ticks while the condition persists, restart on dropout
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || !cond)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    // condition held for the full delay
    always_comb qual = en && cond && (cnt == LIM);
endmodule

// File: rtl/guard_regs.sv
// Host-visible flag and permission bits. Host writes land at the clock
// edge. Hardware sets (fault flags, the wake forcing of CE/DE) and the
// switch-pin clear of PSF take priority over a host write in the same cycle.
module guard_regs
    import cell_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_ov,
    input  logic              set_uv,
    input  logic              set_doc,
    input  logic              set_ot,
    input  logic              clr_psf,
    input  logic              force_en,
    output logic              ce,
    output logic              de,
    output logic              ov,
    output logic              uv,
    output logic              doc,
    output logic              ot,
    output logic              psf
);
    logic wr_prot, wr_feat;
    logic unused_bits;

    always_comb wr_prot = wr_en && (wr_addr == ADDR_PROT);
    always_comb wr_feat = wr_en && (wr_addr == ADDR_FEAT);
    assign unused_bits = ^{wr_data[DATA_W-1:B_OV+1], wr_data[B_DSG:B_CHG]};

    // protection register bits: host write, then hardware overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce  <= 1'b1;
            de  <= 1'b1;
            ov  <= 1'b0;
            uv  <= 1'b1;
            doc <= 1'b1;
        end else begin
            if (wr_prot) begin
                ce  <= wr_data[B_CE];
                de  <= wr_data[B_DE];
                ov  <= wr_data[B_OV];
                uv  <= wr_data[B_UV];
                doc <= wr_data[B_DOC];
            end
            if (force_en) begin
                ce <= 1'b1;
                de <= 1'b1;
            end
            if (set_ov)  ov  <= 1'b1;
            if (set_uv)  uv  <= 1'b1;
            if (set_doc) doc <= 1'b1;
        end
    end

    // feature register bits: host write, then hardware overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot  <= 1'b0;
            psf <= 1'b1;
        end else begin
            if (wr_feat) begin
                ot  <= wr_data[B_OT];
                psf <= wr_data[B_PSF];
            end
            if (set_ot)  ot  <= 1'b1;
            if (clr_psf) psf <= 1'b0;
        end
    end
endmodule

// File: rtl/cell_guard.sv
// Single-cell protection controller. It qualifies each fault with its own
// tick-counted delay, keeps a lockout per fault class, moves between active
// and sleep modes, and drives the FET, test-current and recovery-charge
// enables. Assumes all comparator inputs are synchronous to clk.
module cell_guard
    import cell_guard_pkg::*;
#(
    parameter int unsigned OV_DLY = 16,
    parameter int unsigned UV_DLY = 16,
    parameter int unsigned OC_DLY = 8,
    parameter int unsigned SC_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmp_ov,
    input  logic              cmp_below_ce,
    input  logic              cmp_uv,
    input  logic              cmp_sc,
    input  logic              cmp_oc,
    input  logic              pack_ok,
    input  logic              charger_on,
    input  logic              hot,
    input  logic              sw_low,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              chg_en,
    output logic              dsg_en,
    output logic              test_en,
    output logic              rechg_en,
    output logic              active
);
    localparam int unsigned DLY_TAB [NQ] = '{OV_DLY, UV_DLY, OC_DLY, SC_DLY};

    logic [NQ-1:0] q_cond, q_hit;
    logic active_q, ov_lock, doc_lock, sc_lock;
    logic wake_req;
    logic ce_bit, de_bit, ov_flag, uv_flag, doc_flag, ot_flag, psf_flag;

    // qualifier inputs in package index order
    always_comb begin
        q_cond         = '0;
        q_cond[QI_OV]  = cmp_ov;
        q_cond[QI_UV]  = cmp_uv;
        q_cond[QI_OC]  = cmp_oc;
        q_cond[QI_SC]  = cmp_sc;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_qual
        qual_timer #(.DLY(DLY_TAB[g])) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (active_q),
            .tick (tick),
            .cond (q_cond[g]),
            .qual (q_hit[g])
        );
    end

    // wake request evaluated only in sleep
    always_comb wake_req = !active_q && !cmp_sc &&
                           (sw_low || (!cmp_uv && charger_on));

    // mode and per-fault lockout state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            ov_lock  <= 1'b0;
            doc_lock <= 1'b0;
            sc_lock  <= 1'b0;
        end else if (!active_q) begin
            if (wake_req) begin
                active_q <= 1'b1;
                ov_lock  <= cmp_ov;
                doc_lock <= 1'b0;
                sc_lock  <= 1'b0;
            end
        end else if (q_hit[QI_UV]) begin
            active_q <= 1'b0;
            ov_lock  <= 1'b0;
            doc_lock <= 1'b0;
            sc_lock  <= 1'b0;
        end else begin
            if (q_hit[QI_OV])
                ov_lock <= 1'b1;
            else if (cmp_below_ce || cmp_oc)
                ov_lock <= 1'b0;
            if (q_hit[QI_OC] || q_hit[QI_SC])
                doc_lock <= 1'b1;
            else if (pack_ok)
                doc_lock <= 1'b0;
            if (q_hit[QI_SC])
                sc_lock <= 1'b1;
            else if (pack_ok)
                sc_lock <= 1'b0;
        end
    end

    guard_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .set_ov  (q_hit[QI_OV] || (wake_req && cmp_ov)),
        .set_uv  (q_hit[QI_UV]),
        .set_doc (q_hit[QI_OC] || q_hit[QI_SC]),
        .set_ot  (hot),
        .clr_psf (sw_low),
        .force_en(wake_req),
        .ce      (ce_bit),
        .de      (de_bit),
        .ov      (ov_flag),
        .uv      (uv_flag),
        .doc     (doc_flag),
        .ot      (ot_flag),
        .psf     (psf_flag)
    );

    // FET and auxiliary enables; temperature acts without a clock edge
    always_comb begin
        chg_en   = active_q && ce_bit && !ov_lock && !doc_lock && !ot_flag && !hot;
        dsg_en   = active_q && de_bit && !doc_lock && !ot_flag && !hot;
        test_en  = active_q && doc_lock;
        rechg_en = active_q && sc_lock;
        active   = active_q;
    end

    // host read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_PROT) begin
            reg_rdata[B_CE]  = ce_bit;
            reg_rdata[B_DE]  = de_bit;
            reg_rdata[B_CHG] = chg_en;
            reg_rdata[B_DSG] = dsg_en;
            reg_rdata[B_DOC] = doc_flag;
            reg_rdata[B_UV]  = uv_flag;
            reg_rdata[B_OV]  = ov_flag;
        end else begin
            reg_rdata[B_OT]  = ot_flag;
            reg_rdata[B_PSF] = psf_flag;
        end
    end
endmodule

// File: rtl/guard_chk.sv
// Property checker for cell_guard, attached by the bind at the end of
// this file. Assumes the synchronous active-low reset of the design.
module guard_chk (
    input logic clk,
    input logic rst_n,
    input logic active,
    input logic chg_en,
    input logic dsg_en,
    input logic test_en,
    input logic rechg_en,
    input logic hot,
    input logic ce_bit,
    input logic de_bit,
    input logic ov_flag,
    input logic psf_flag,
    input logic reg_wr,
    input logic reg_addr,
    input logic sw_low
);
    // R7
    sleep_fets_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!chg_en && !dsg_en));
    // R9
    hot_fets_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot |-> (!chg_en && !dsg_en));
    // R10
    ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_bit |-> !chg_en);
    // R10
    de_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_bit |-> !dsg_en);
    // R5
    test_path_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |-> (!chg_en && !dsg_en));
    // R5
    rechg_under_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rechg_en |-> test_en);
    // R11
    ov_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag && !(reg_wr && reg_addr == 1'b0)) |=> ov_flag);
    // R12
    psf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_low |=> !psf_flag);
endmodule

bind cell_guard guard_chk u_guard_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .chg_en  (chg_en),
    .dsg_en  (dsg_en),
    .test_en (test_en),
    .rechg_en(rechg_en),
    .hot     (hot),
    .ce_bit  (ce_bit),
    .de_bit  (de_bit),
    .ov_flag (ov_flag),
    .psf_flag(psf_flag),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .sw_low  (sw_low)
);

// File: tb/test_cell_guard.sv
// Bench for cell_guard: a table of steady input patterns from reset,
// then directed sequences for delays, recovery, sleep and register bits.
module test_cell_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       cmp_ov, cmp_below_ce, cmp_uv, cmp_sc, cmp_oc;
    logic       pack_ok, charger_on, hot, sw_low;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       chg_en, dsg_en, test_en, rechg_en, active;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    cell_guard #(.OV_DLY(3), .UV_DLY(4), .OC_DLY(2), .SC_DLY(1)) i_cell_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmp_ov(cmp_ov), .cmp_below_ce(cmp_below_ce), .cmp_uv(cmp_uv),
        .cmp_sc(cmp_sc), .cmp_oc(cmp_oc), .pack_ok(pack_ok),
        .charger_on(charger_on), .hot(hot), .sw_low(sw_low),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .chg_en(chg_en), .dsg_en(dsg_en),
        .test_en(test_en), .rechg_en(rechg_en), .active(active)
    );

    // stimulus bits: [8]ov [7]below_ce [6]uv [5]sc [4]oc [3]pack_ok [2]charger [1]hot [0]sw_low
    // expected bits: [4]active [3]chg [2]dsg [1]test [0]rechg
    localparam int NV = 10;
    localparam logic [13:0] VEC [NV] = '{
        {9'h000, 5'b11100},   // R1 quiet cell
        {9'h100, 5'b10100},   // R2 overvoltage
        {9'h010, 5'b10010},   // R5 overcurrent
        {9'h020, 5'b10011},   // R5 depletion
        {9'h002, 5'b10000},   // R9 overtemperature
        {9'h040, 5'b00000},   // R6 undervoltage
        {9'h001, 5'b11100},   // R7 switch low while active
        {9'h004, 5'b11100},   // R7 charger while active
        {9'h080, 5'b11100},   // R3 below charge-enable only
        {9'h008, 5'b11100}    // R5 pack recovered only
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic setin(input logic [8:0] v);
        {cmp_ov, cmp_below_ce, cmp_uv, cmp_sc, cmp_oc, pack_ok, charger_on, hot, sw_low} = v;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        setin(9'h000);
        reg_wr = 1'b0;
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] outs();
        return {3'b000, active, chg_en, dsg_en, test_en, rechg_en};
    endfunction

    function automatic logic [7:0] rd(input logic a);
        reg_addr = a;
        return reg_rdata;
    endfunction

    task automatic rdchk(input string tag, input logic a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        setin(9'h000);

        // table walk, each pattern from a fresh reset
        for (int i = 0; i < NV; i++) begin
            do_reset();
            setin(VEC[i][13:5]);
            step(8);
            check($sformatf("R1..table vector %0d (R2 R5 R6 R7 R9)", i), outs(), {3'b000, VEC[i][4:0]});
        end

        // R1 reset register values
        do_reset();
        rdchk("R1 prot reset", 1'b0, 8'h3F);
        rdchk("R1 feat reset", 1'b1, 8'h02);

        // R2 overvoltage delay edge: on after 3 ticks, off after 4
        do_reset();
        setin(9'h100);
        step(3);
        check("R2 before trip", outs(), 8'h1C);
        step(1);
        check("R2 after trip", outs(), 8'h14);
        rdchk("R2 OV flag", 1'b0, 8'h7B);

        // R3 recovery via charge-enable level, R11 flag stays
        setin(9'h000);
        step(3);
        check("R3 lock held", outs(), 8'h14);
        setin(9'h080);
        step(1);
        check("R3 below ce recovery", outs(), 8'h1C);
        rdchk("R11 OV still set", 1'b0, 8'h7F);
        setin(9'h000);
        wr(1'b0, 8'h03);
        rdchk("R11 host clears flags", 1'b0, 8'h0F);

        // R4 restart of the delay count
        do_reset();
        setin(9'h100);
        step(2);
        setin(9'h000);
        step(1);
        setin(9'h100);
        step(3);
        check("R4 restarted count", outs(), 8'h1C);
        step(1);
        check("R4 trip after full delay", outs(), 8'h14);

        // R3 recovery via discharge current
        setin(9'h010);
        step(1);
        check("R3 oc recovery", outs(), 8'h1C);
        setin(9'h000);

        // R5 overcurrent lockout and release
        do_reset();
        wr(1'b0, 8'h03);
        setin(9'h010);
        step(2);
        check("R5 oc before trip", outs(), 8'h1C);
        step(1);
        check("R5 oc lockout", outs(), 8'h12);
        setin(9'h000);
        step(3);
        check("R5 oc lock held", outs(), 8'h12);
        rdchk("R5 DOC flag", 1'b0, 8'h13);
        setin(9'h008);
        step(1);
        check("R5 pack release", outs(), 8'h1C);

        // R5 depletion lockout with recovery charge
        do_reset();
        wr(1'b0, 8'h03);
        setin(9'h020);
        step(2);
        check("R5 sc lockout", outs(), 8'h13);
        setin(9'h008);
        step(1);
        check("R5 sc release", outs(), 8'h1C);

        // R10 host permission bits
        do_reset();
        wr(1'b0, 8'h02);
        check("R10 CE=0", outs(), 8'h14);
        wr(1'b0, 8'h01);
        check("R10 DE=0", outs(), 8'h18);
        wr(1'b0, 8'h03);
        check("R10 both back", outs(), 8'h1C);

        // R9 overtemperature
        do_reset();
        setin(9'h002);
        #1;
        check("R9 immediate off", outs(), 8'h10);
        step(2);
        wr(1'b1, 8'h02);
        setin(9'h000);
        step(1);
        check("R9 clear while hot ignored", outs(), 8'h10);
        rdchk("R9 OT flag", 1'b1, 8'h03);
        wr(1'b1, 8'h02);
        check("R9 cooled and cleared", outs(), 8'h1C);
        wr(1'b1, 8'h03);
        check("R9 host forces off", outs(), 8'h10);
        wr(1'b1, 8'h02);
        check("R9 host release", outs(), 8'h1C);

        // R6 undervoltage into sleep, R7 sleep behaviour, R8 wake
        do_reset();
        wr(1'b0, 8'h00);
        setin(9'h040);
        step(5);
        check("R6 sleep entry", outs(), 8'h00);
        rdchk("R6 UV flag", 1'b0, 8'h20);
        setin(9'h100);
        step(6);
        rdchk("R7 no OV in sleep", 1'b0, 8'h20);
        setin(9'h061);
        step(2);
        check("R7 wake refused in depletion", outs(), 8'h00);
        setin(9'h101);
        step(1);
        check("R8 wake with OV at once", outs(), 8'h14);
        rdchk("R8 CE DE forced", 1'b0, 8'h6B);
        setin(9'h080);
        step(1);
        check("R8 charge back", outs(), 8'h1C);

        // R7 charger wake
        do_reset();
        setin(9'h040);
        step(5);
        setin(9'h044);
        step(3);
        check("R7 charger but low cell", outs(), 8'h00);
        setin(9'h004);
        step(1);
        check("R7 charger wake", outs(), 8'h1C);

        // R12 switch flag
        do_reset();
        setin(9'h001);
        step(1);
        rdchk("R12 PSF cleared", 1'b1, 8'h00);
        setin(9'h000);
        step(2);
        rdchk("R12 PSF stays low", 1'b1, 8'h00);
        wr(1'b1, 8'h02);
        rdchk("R12 PSF host set", 1'b1, 8'h02);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule